// File: doc/BRIEF.md
# Bus Arbiter Fault Interrupt Unit

This block sits beside a parallel bus arbiter that serves four requesting masters. It watches each grant. When a master holds its grant for a fixed number of clocks and never begins a transaction, the block marks that master as broken. The block also catches one-clock low pulses on the shared active-low system-error line, which external agents drive. Each fault source has its own sticky status bit.

Software uses a small register port to read and write two registers: a status register and an enable mask. Writing a 1 to a status bit inverts that bit. A bit that is set is cleared, which acknowledges it. A bit that is clear is set, which lets software force an interrupt for diagnostics. A single registered interrupt output is raised when any status bit is set and its enable bit is also set.

The block does not arbitrate. It does not check parity and does not decode configuration space.

Top module: `arb_fault_irq`

## Requirements
- R1: After reset, and whenever reset is asserted, all status bits, all enable bits and `irq` are 0.
- R2: Master m (status bit m, for m = 0..3) is flagged broken when its grant is sampled high on 16 consecutive rising edges and its start indication is low on all of them. The bit reads 1 right after the 16th such edge. After 15 such edges it still reads 0.
- R3: The count for a master stops and is discarded when that master's start indication is sampled high while it is granted, or when its grant is sampled low. No flag is raised afterwards while the same grant continues.
- R4: A new grant, meaning a rising edge of the grant after it was sampled low, restarts the count from zero.
- R5: When `serr_n` is sampled low on one rising edge, status bit 4 reads 1 after the following rising edge.
- R6: Writing 1 to a status bit that reads 1 clears that bit.
- R7: Writing 1 to a status bit that reads 0 sets that bit. Writing 0 to a status bit leaves it unchanged.
- R8: When a hardware set event and a software write of 1 reach the same status bit on the same edge, the bit ends up 1.
- R9: Offset 0 selects the status register and offset 1 selects the enable register. Enable bits 4:0 are read/write and line up with status bits 4:0. All other offsets read 0, and writes to them change nothing.
- R10: `irq` equals the OR of (status AND enable) as it stood before the previous rising edge. It therefore changes exactly one edge after a status or enable change.
- R11: Status bit 5 shows the live level of `clk_running` and ignores writes. Bits 31:6 of the status register, and bits 31:5 of the enable register, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 4 | Per-master grant from the arbiter, active high |
| bus_start | input | 4 | Per-master transaction-start indication, active high |
| serr_n | input | 1 | Shared system-error line, active low |
| clk_running | input | 1 | Bus clock running flag, read back at status bit 5 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 status, 1 enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
The result of a register write can be read back right after the edge that takes the write, because read data is combinational. A broken-master bit becomes readable right after the 16th qualifying grant edge. A system-error pulse reaches its status bit one edge after the edge that samples it. The interrupt output follows any status or enable change one edge later still. The bench drives inputs just after the falling edge and samples just before the next falling edge. It checks each result at its first due point and also at the point one edge earlier, so that a result arriving one cycle early or one cycle late is reported.

// File: rtl/afi_pkg.sv
package afi_pkg;
    localparam int STATUS_OFS = 0;
    localparam int ENABLE_OFS = 1;
endpackage

// File: rtl/afi_grant_timer.sv
module afi_grant_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic start,
    output logic fire
);
    localparam int CW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic          gnt_prev;
        logic          armed;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s          tmr_d, tmr_q;
    logic          new_gnt;
    logic [CW-1:0] base;

    always_comb begin
        tmr_d          = tmr_q;
        fire           = 1'b0;
        tmr_d.gnt_prev = grant;
        new_gnt        = grant & ~tmr_q.gnt_prev;
        base           = new_gnt ? '0 : tmr_q.cnt;
        if (grant && !start && (new_gnt || tmr_q.armed)) begin
            if (base == CW'(TIMEOUT - 1)) begin
                fire        = 1'b1;
                tmr_d.armed = 1'b0;
                tmr_d.cnt   = '0;
            end else begin
                tmr_d.armed = 1'b1;
                tmr_d.cnt   = CW'(base + 1'b1);
            end
        end else begin
            tmr_d.armed = 1'b0;
            tmr_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/afi_serr_capture.sv
module afi_serr_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic serr_n,
    output logic evt
);
    typedef struct packed {
        logic low;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.low = ~serr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign evt = cap_q.low;
endmodule

// File: rtl/afi_status_regs.sv
module afi_status_regs
    import afi_pkg::*;
#(
    parameter int NSRC   = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   hw_set,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clk_run,
    output logic [NSRC-1:0]   status,
    output logic [NSRC-1:0]   enable,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    typedef struct packed {
        logic [NSRC-1:0] status;
        logic [NSRC-1:0] enable;
        logic            irq;
    } regs_s;

    regs_s           regs_d, regs_q;
    logic            sel_status, sel_enable;
    logic [NSRC-1:0] toggle;
    logic            unused_wdata;

    assign sel_status   = addr == ADDR_W'(STATUS_OFS);
    assign sel_enable   = addr == ADDR_W'(ENABLE_OFS);
    assign unused_wdata = ^wdata[DATA_W-1:NSRC];

    always_comb begin
        regs_d        = regs_q;
        toggle        = (wr_en && sel_status) ? wdata[NSRC-1:0] : '0;
        regs_d.status = (regs_q.status ^ toggle) | hw_set;
        if (wr_en && sel_enable) regs_d.enable = wdata[NSRC-1:0];
        regs_d.irq    = |(regs_q.status & regs_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (sel_status) begin
            rdata[NSRC-1:0] = regs_q.status;
            rdata[NSRC]     = clk_run;
        end else if (sel_enable) begin
            rdata[NSRC-1:0] = regs_q.enable;
        end
    end

    assign status = regs_q.status;
    assign enable = regs_q.enable;
    assign irq    = regs_q.irq;
endmodule

// File: rtl/arb_fault_irq.sv
module arb_fault_irq #(
    parameter int NUM_MASTERS = 4,
    parameter int TIMEOUT     = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] bus_grant,
    input  logic [NUM_MASTERS-1:0] bus_start,
    input  logic                   serr_n,
    input  logic                   clk_running,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic                   irq
);
    localparam int NSRC = NUM_MASTERS + 1;

    logic [NSRC-1:0] hw_set_w;
    logic [NSRC-1:0] status_w;
    logic [NSRC-1:0] enable_w;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_tmr
        afi_grant_timer #(.TIMEOUT(TIMEOUT)) tmr_i (
            .clk  (clk),
            .rst_n(rst_n),
            .grant(bus_grant[m]),
            .start(bus_start[m]),
            .fire (hw_set_w[m])
        );
    end

    afi_serr_capture serr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .serr_n(serr_n),
        .evt   (hw_set_w[NUM_MASTERS])
    );

    afi_status_regs #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set_w),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .clk_run(clk_running),
        .status (status_w),
        .enable (enable_w),
        .rdata  (reg_rdata),
        .irq    (irq)
    );
endmodule

// File: rtl/afi_checker.sv
module afi_checker #(
    parameter int NSRC   = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              serr_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [NSRC-1:0]   status_q,
    input logic [NSRC-1:0]   enable_q,
    input logic [NSRC-1:0]   hw_set
);
    // R10: interrupt is one edge behind the masked status
    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status_q & enable_q))));

    // R5: a sampled low error pulse lands in bit 4 one edge later
    assert_serr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> ##1 status_q[NSRC-1]);

    // R11: reserved read bits
    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NSRC+1] == '0);

    // R9: enable write takes the written low bits
    assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1)) |=> (enable_q == $past(reg_wdata[NSRC-1:0])));

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // R7: writing 1 to a clear bit sets it
        assert_force_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == '0 && reg_wdata[i] && !status_q[i]) |=> status_q[i]);
        // R6: writing 1 to a set bit clears it when hardware is quiet
        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == '0 && reg_wdata[i] && status_q[i] && !hw_set[i]) |=> !status_q[i]);
        // R8: a hardware set always leaves the bit at 1
        assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> status_q[i]);
    end
endmodule

bind arb_fault_irq afi_checker #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .serr_n   (serr_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .status_q (status_w),
    .enable_q (enable_w),
    .hw_set   (hw_set_w)
);

// File: tb/arb_fault_irq_tb_top.sv
module arb_fault_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_grant = '0;
    logic [3:0]  bus_start = '0;
    logic        serr_n = 1'b1;
    logic        clk_running = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    arb_fault_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_start(bus_start),
        .serr_n(serr_n), .clk_running(clk_running), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // entry: {req[3:0], wr, addr[1:0], wdata[7:0], expected read[7:0]}
    localparam int NVEC = 10;
    localparam logic [22:0] VEC [NVEC] = '{
        {4'd9,  1'b1, 2'd1, 8'h1F, 8'h1F},  // R9 enable write
        {4'd7,  1'b1, 2'd0, 8'h05, 8'h25},  // R7 force bits 0,2
        {4'd6,  1'b1, 2'd0, 8'h04, 8'h21},  // R6 clear bit 2
        {4'd7,  1'b1, 2'd0, 8'h00, 8'h21},  // R7 zero write keeps
        {4'd11, 1'b1, 2'd0, 8'hFF, 8'h3E},  // R11 toggle low 5, upper ignored
        {4'd9,  1'b1, 2'd2, 8'hFF, 8'h00},  // R9 unused offset reads 0
        {4'd9,  1'b0, 2'd0, 8'h00, 8'h3E},  // R9 status untouched by offset 2
        {4'd11, 1'b1, 2'd1, 8'hE3, 8'h03},  // R11 enable upper bits ignored
        {4'd6,  1'b1, 2'd0, 8'h1E, 8'h20},  // R6 clear all
        {4'd9,  1'b1, 2'd1, 8'h00, 8'h00}   // R9 enable back to 0
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        @(negedge clk);
        tick();
        // R1 reset state
        rd_reg(2'd0, rd); check("R1 status", rd, 32'h20);
        rd_reg(2'd1, rd); check("R1 enable", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        for (int k = 0; k < NVEC; k++) begin
            reg_addr  = VEC[k][17:16];
            reg_wdata = {24'b0, VEC[k][15:8]};
            reg_wr    = VEC[k][18];
            tick();
            reg_wr = 1'b0;
            #1;
            check($sformatf("R%0d vec %0d", VEC[k][22:19], k), reg_rdata, {24'b0, VEC[k][7:0]});
        end

        // R2 timeout on master 2
        reg_addr = 2'd0;
        bus_grant[2] = 1'b1;
        repeat (15) tick();
        rd_reg(2'd0, rd); check("R2 after 15", rd & 32'h04, 32'h0);
        tick();
        rd_reg(2'd0, rd); check("R2 after 16", rd & 32'h04, 32'h04);
        bus_grant[2] = 1'b0;
        tick();
        wr_reg(2'd0, 32'h04);
        rd_reg(2'd0, rd); check("R6 clear timeout bit", rd & 32'h1F, 32'h0);

        // R3 start cancels the count
        bus_grant[1] = 1'b1;
        repeat (9) tick();
        bus_start[1] = 1'b1; tick(); bus_start[1] = 1'b0;
        repeat (20) tick();
        rd_reg(2'd0, rd); check("R3 start cancels", rd & 32'h02, 32'h0);
        bus_grant[1] = 1'b0;
        tick();

        // R3 grant drop cancels, R4 new grant restarts
        bus_grant[3] = 1'b1; repeat (10) tick();
        bus_grant[3] = 1'b0; tick();
        bus_grant[3] = 1'b1; repeat (15) tick();
        rd_reg(2'd0, rd); check("R4 restart 15", rd & 32'h08, 32'h0);
        tick();
        rd_reg(2'd0, rd); check("R4 restart 16", rd & 32'h08, 32'h08);
        bus_grant[3] = 1'b0;
        wr_reg(2'd0, 32'h08);

        // R8 hardware set beats simultaneous clear
        wr_reg(2'd0, 32'h01);
        rd_reg(2'd0, rd); check("R7 force bit0", rd & 32'h01, 32'h01);
        bus_grant[0] = 1'b1; repeat (15) tick();
        wr_reg(2'd0, 32'h01);
        rd_reg(2'd0, rd); check("R8 hw wins", rd & 32'h01, 32'h01);
        bus_grant[0] = 1'b0;
        wr_reg(2'd0, 32'h01);
        rd_reg(2'd0, rd); check("R6 clear bit0", rd & 32'h1F, 32'h0);

        // R5 error pulse
        serr_n = 1'b0; tick(); serr_n = 1'b1;
        rd_reg(2'd0, rd); check("R5 one edge", rd & 32'h10, 32'h0);
        tick();
        rd_reg(2'd0, rd); check("R5 two edges", rd & 32'h10, 32'h10);

        // R10 irq latency
        wr_reg(2'd1, 32'h10);
        check("R10 irq not yet", {31'b0, irq}, 32'h0);
        tick();
        check("R10 irq set", {31'b0, irq}, 32'h1);
        wr_reg(2'd0, 32'h10);
        check("R10 irq held", {31'b0, irq}, 32'h1);
        tick();
        check("R10 irq cleared", {31'b0, irq}, 32'h0);

        // R11 live flag and reserved writes
        clk_running = 1'b0;
        rd_reg(2'd0, rd); check("R11 flag low", rd, 32'h0);
        clk_running = 1'b1;
        wr_reg(2'd0, 32'hFFFF_FFE0);
        rd_reg(2'd0, rd); check("R11 reserved write", rd, 32'h20);

        // R1 reset mid-run
        wr_reg(2'd0, 32'h0F);
        wr_reg(2'd1, 32'h0F);
        tick();
        check("R10 irq on", {31'b0, irq}, 32'h1);
        rst_n = 1'b0;
        #1;
        rd_reg(2'd0, rd); check("R1 status reset", rd, 32'h20);
        rd_reg(2'd1, rd); check("R1 enable reset", rd, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        tick();
        rst_n = 1'b1;
        tick();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule